// File: doc/BRIEF.md
# Nine-Bit Multidrop Address-Filtered Receiver

This block sits on a one-way asynchronous serial line that is shared by many identical receivers. Every character on the line has nine data bits. The ninth bit marks the character as either an address or a data byte. The block recovers each character with a 16x oversampling receiver. It compares address characters against a window of channel addresses set by configuration pins. When a data byte follows an address inside that window, the block presents the byte as a register write for the local channel.

The window is set by two static inputs, a first address and a last address, so swapping boards only requires a different pin strapping. The write appears as a one-cycle strobe. It carries the channel index, which is the address minus the window base, and the 8-bit value. The block never drives the line.

Top module: `mdrx_top`

## Requirements
- R1: A character is one low start bit, then nine data bits sent least significant bit first, then one high stop bit. Each bit lasts 16*TICK_DIV clock cycles, and each bit is sampled at its middle.
- R2: The ninth data bit (bit 8) set to 1 marks an address character whose bits 7:0 hold the address. Bit 8 set to 0 marks a data character whose bits 7:0 hold the value. Only a data character can produce a write.
- R3: An address character with win_base_i <= address <= win_last_i arms the receiver. The write that follows carries wr_idx_o = address - win_base_i.
- R4: A data character that arrives while the receiver is armed produces exactly one single-cycle wr_o pulse, with wr_data_o equal to the data byte.
- R5: After a match, only the first data character is written. Further data characters are ignored until the next address character.
- R6: A data character is ignored when no matching address precedes it. An address outside the window disarms the receiver.
- R7: A stop bit sampled low produces a single-cycle frame_err_o pulse and drops the character, leaving the armed state unchanged. The receiver then waits for the line to return high before looking for a new start bit.
- R8: After reset, wr_o and frame_err_o are low and the receiver is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high, asynchronous |
| win_base_i | input | 8 | First address of the window |
| win_last_i | input | 8 | Last address of the window (inclusive) |
| wr_o | output | 1 | One-cycle write strobe |
| wr_idx_o | output | 8 | Local channel index of the write |
| wr_data_o | output | 8 | Value written |
| frame_err_o | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The bench builds the block with TICK_DIV set to 1, so one oversample tick equals one clock and a full character takes 176 cycles. At that rate, all 256 address values fit in one run, each followed by a data byte, with a 16-address window whose expected index and value are computed arithmetically. Further short sequences cover a one-address window, a window at the top of the address space, repeated data, a missing or non-matching address, and a bad stop bit between an address and its data.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;
  localparam int CHAR_W = 9;
  localparam int ADDR_W = 8;
  localparam int OVS    = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BREAK
  } rx_state_e;
endpackage

// File: rtl/mdrx_sync.sv
module mdrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/mdrx_deframer.sv
module mdrx_deframer
  import mdrx_pkg::*;
#(
  parameter int TICK_DIV = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic              char_vld_o,
  output logic              frm_err_o,
  output logic [CHAR_W-1:0] char_o
);
  localparam int SUB_W = $clog2(OVS);
  localparam int BIT_W = $clog2(CHAR_W);
  localparam logic [SUB_W-1:0] MID  = SUB_W'(OVS/2 - 1);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(OVS - 1);
  localparam logic [BIT_W-1:0] NBIT = BIT_W'(CHAR_W - 1);

  logic tick;

  generate
    if (TICK_DIV == 1) begin : g_tick_every
      assign tick = 1'b1;
    end else begin : g_tick_div
      localparam int DIV_W = $clog2(TICK_DIV);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          div_q <= '0;
        else if (div_q == DIV_W'(TICK_DIV-1)) div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DIV_W'(TICK_DIV-1));
    end
  endgenerate

  rx_state_e         st_q;
  logic [SUB_W-1:0]  sub_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CHAR_W-1:0] shr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      sub_q      <= '0;
      bit_q      <= '0;
      shr_q      <= '0;
      char_vld_o <= 1'b0;
      frm_err_o  <= 1'b0;
      char_o     <= '0;
    end else begin
      char_vld_o <= 1'b0;
      frm_err_o  <= 1'b0;
      case (st_q)
        ST_IDLE: if (tick && !rx_i) begin
          st_q  <= ST_START;
          sub_q <= '0;
        end
        ST_START: if (tick) begin
          if (sub_q == MID) begin
            sub_q <= '0;
            bit_q <= '0;
            st_q  <= rx_i ? ST_IDLE : ST_DATA;  // reject glitch
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        ST_DATA: if (tick) begin
          if (sub_q == LAST) begin
            sub_q <= '0;
            shr_q <= {rx_i, shr_q[CHAR_W-1:1]};
            if (bit_q == NBIT) st_q <= ST_STOP;
            else               bit_q <= bit_q + 1'b1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        ST_STOP: if (tick) begin
          if (sub_q == LAST) begin
            sub_q <= '0;
            if (rx_i) begin
              char_vld_o <= 1'b1;
              char_o     <= shr_q;
              st_q       <= ST_IDLE;
            end else begin
              frm_err_o  <= 1'b1;
              st_q       <= ST_BREAK;
            end
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        ST_BREAK: if (rx_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_vld_high_stop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_o |-> ($past(rx_i) && $past(st_q == ST_STOP)));

  assert_err_low_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_o |-> (!$past(rx_i) && $past(st_q == ST_STOP)));

  assert_err_waits_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_o |-> (st_q == ST_BREAK));
endmodule

// File: rtl/mdrx_filter.sv
module mdrx_filter
  import mdrx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_vld_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic [ADDR_W-1:0] win_base_i,
  input  logic [ADDR_W-1:0] win_last_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_idx_o,
  output logic [7:0]        wr_data_o
);
  logic              armed_q;
  logic [ADDR_W-1:0] pend_idx_q;
  logic              is_addr;
  logic [ADDR_W-1:0] addr;
  logic              hit;

  assign is_addr = char_i[CHAR_W-1];
  assign addr    = char_i[ADDR_W-1:0];
  assign hit     = (addr >= win_base_i) && (addr <= win_last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      pend_idx_q <= '0;
      wr_o       <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_o <= 1'b0;
      if (char_vld_i) begin
        if (is_addr) begin
          armed_q    <= hit;
          pend_idx_q <= addr - win_base_i;
        end else if (armed_q) begin
          wr_o      <= 1'b1;
          wr_idx_o  <= pend_idx_q;
          wr_data_o <= char_i[7:0];
          armed_q   <= 1'b0;  // first data only
        end
      end
    end
  end

  assert_wr_from_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(char_vld_i && !char_i[CHAR_W-1]));

  assert_wr_needs_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(armed_q));

  assert_wr_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);

  assert_disarm_after_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !armed_q);
endmodule

// File: rtl/mdrx_top.sv
module mdrx_top
  import mdrx_pkg::*;
#(
  parameter int TICK_DIV    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [ADDR_W-1:0] win_base_i,
  input  logic [ADDR_W-1:0] win_last_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_idx_o,
  output logic [7:0]        wr_data_o,
  output logic              frame_err_o
);
  logic              rx_s;
  logic              char_vld;
  logic [CHAR_W-1:0] char_w;

  mdrx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s)
  );

  mdrx_deframer #(.TICK_DIV(TICK_DIV)) i_deframer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_s),
    .char_vld_o (char_vld),
    .frm_err_o  (frame_err_o),
    .char_o     (char_w)
  );

  mdrx_filter i_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .char_vld_i (char_vld),
    .char_i     (char_w),
    .win_base_i (win_base_i),
    .win_last_i (win_last_i),
    .wr_o       (wr_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_data_o)
  );

  assert_no_wr_on_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_o && frame_err_o));
endmodule

// File: tb/test_mdrx_top.sv
module test_mdrx_top;
  localparam int TICK_DIV = 1;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [7:0] win_base = 8'h40;
  logic [7:0] win_last = 8'h4F;
  logic       wr;
  logic [7:0] wr_idx;
  logic [7:0] wr_data;
  logic       ferr;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  int ferr_cnt = 0;
  int wr_pulse_len = 0;
  int wr_long = 0;
  logic [7:0] last_idx = '0;
  logic [7:0] last_data = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mdrx_top #(.TICK_DIV(TICK_DIV)) i_mdrx_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_i        (rx),
    .win_base_i  (win_base),
    .win_last_i  (win_last),
    .wr_o        (wr),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data),
    .frame_err_o (ferr)
  );

  always @(negedge clk) begin
    if (wr) begin
      wr_cnt++;
      last_idx  = wr_idx;
      last_data = wr_data;
      wr_pulse_len++;
      if (wr_pulse_len > 1) wr_long++;
    end else begin
      wr_pulse_len = 0;
    end
    if (ferr) ferr_cnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_char(input logic [8:0] c, input bit stop_ok);
    @(negedge clk) rx = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int b = 0; b < 9; b++) begin
      rx = c[b];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rx = stop_ok;
    repeat (BIT_CLKS) @(negedge clk);
    rx = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic send_addr(input logic [7:0] a);
    send_char({1'b1, a}, 1'b1);
  endtask

  task automatic send_data(input logic [7:0] d);
    send_char({1'b0, d}, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w0;
    int e0;
    repeat (5) @(negedge clk);
    // R8: reset state
    check(wr == 1'b0, "R8", "wr_o in reset", wr, 0);
    check(ferr == 1'b0, "R8", "frame_err_o in reset", ferr, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8: not armed after reset, data alone gives no write
    w0 = wr_cnt;
    send_data(8'h11);
    check(wr_cnt == w0, "R8", "writes after data from reset", wr_cnt - w0, 0);

    // R1 R2 R3 R4: sweep every address with window 0x40..0x4F
    for (int a = 0; a < 256; a++) begin
      bit inside_w;
      logic [7:0] d;
      inside_w = (a >= 'h40) && (a <= 'h4F);
      d = 8'(a) ^ 8'h5A;
      w0 = wr_cnt;
      send_addr(8'(a));
      send_data(d);
      if (inside_w)
        check((wr_cnt == w0 + 1) && (last_idx == 8'(a - 'h40)) && (last_data == d),
              "R3", "in-window write idx/data", {last_idx, last_data},
              {8'(a - 'h40), d});
      else
        check(wr_cnt == w0, "R6", "out-of-window write count", wr_cnt - w0, 0);
    end
    check(wr_long == 0, "R4", "strobe longer than one cycle", wr_long, 0);

    // R5: only first data after a match
    w0 = wr_cnt;
    send_addr(8'h45);
    send_data(8'hA1);
    send_data(8'hA2);
    send_data(8'hA3);
    check(wr_cnt == w0 + 1, "R5", "writes for three data", wr_cnt - w0, 1);
    check(last_data == 8'hA1, "R5", "value kept", last_data, 8'hA1);

    // R6: non-matching address disarms
    w0 = wr_cnt;
    send_addr(8'h47);
    send_addr(8'h90);
    send_data(8'h33);
    check(wr_cnt == w0, "R6", "write after disarming address", wr_cnt - w0, 0);

    // R6: re-address inside window replaces pending index
    w0 = wr_cnt;
    send_addr(8'h41);
    send_addr(8'h4E);
    send_data(8'h77);
    check((wr_cnt == w0 + 1) && (last_idx == 8'h0E), "R3", "latest address index",
          last_idx, 8'h0E);

    // R7: bad stop bit on data dropped, arm kept, frame error pulsed
    w0 = wr_cnt;
    e0 = ferr_cnt;
    send_addr(8'h42);
    send_char({1'b0, 8'hEE}, 1'b0);
    check(ferr_cnt == e0 + 1, "R7", "frame error pulses", ferr_cnt - e0, 1);
    check(wr_cnt == w0, "R7", "write from bad frame", wr_cnt - w0, 0);
    send_data(8'h99);
    check((wr_cnt == w0 + 1) && (last_idx == 8'h02) && (last_data == 8'h99), "R7",
          "write after dropped char", {last_idx, last_data}, {8'h02, 8'h99});

    // R7: bad stop on address leaves prior disarmed state
    w0 = wr_cnt;
    send_char({1'b1, 8'h43}, 1'b0);
    send_data(8'h12);
    check(wr_cnt == w0, "R7", "write after bad address frame", wr_cnt - w0, 0);

    // R1: data bit order, value with single ninth-bit-like pattern
    w0 = wr_cnt;
    send_addr(8'h40);
    send_data(8'h80);
    check((wr_cnt == w0 + 1) && (last_data == 8'h80), "R1", "msb-only byte",
          last_data, 8'h80);
    send_addr(8'h4F);
    send_data(8'h01);
    check((last_idx == 8'h0F) && (last_data == 8'h01), "R1", "lsb-only byte",
          {last_idx, last_data}, {8'h0F, 8'h01});

    // R3: single-address window at top of range
    win_base = 8'hFF;
    win_last = 8'hFF;
    repeat (4) @(negedge clk);
    w0 = wr_cnt;
    send_addr(8'hFE);
    send_data(8'h21);
    check(wr_cnt == w0, "R3", "below one-address window", wr_cnt - w0, 0);
    send_addr(8'hFF);
    send_data(8'h22);
    check((wr_cnt == w0 + 1) && (last_idx == 8'h00) && (last_data == 8'h22), "R3",
          "one-address window hit", {last_idx, last_data}, {8'h00, 8'h22});

    // R3: window starting at zero
    win_base = 8'h00;
    win_last = 8'h03;
    repeat (4) @(negedge clk);
    w0 = wr_cnt;
    send_addr(8'h03);
    send_data(8'h5C);
    send_addr(8'h04);
    send_data(8'h5D);
    check((wr_cnt == w0 + 1) && (last_idx == 8'h03) && (last_data == 8'h5C), "R3",
          "upper edge of zero-based window", {last_idx, last_data}, {8'h03, 8'h5C});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule